// File: doc/BRIEF.md
# Bridge Read Deadlock Breaker

This block sits beside a bridge that joins a split-capable host system bus to a PCI-style I/O bus. It watches the request and grant status of both bus interfaces. A host read that targets the I/O bus can stall while the I/O side is busy. At the same time, a DMA read that targets host memory can stall while the host side is busy. If both stall together, each read waits for the other to finish and neither can move. When the block sees both reads waiting, it tells the host interface to split its transaction. This frees the host bus so that the DMA read can finish.

The two buses run on unrelated clocks. The I/O-side status passes through a multi-flop synchroniser before the host-domain decision logic uses it. The I/O interface reports that a DMA read has delivered its return data with a one-cycle pulse. That pulse crosses the clock domains as a toggle. The block keeps a flag set from the split until that report arrives. It then pulses a retry strobe so the host side can reissue its read. A saturating counter of issued splits is available at the ports.

Top module: `bdb_deadlock_breaker`

## Requirements
- R1: While reset is active, and in the first cycle after it, hostSplit, hostRetry and splitHeld are 0 and splitCount is 0.
- R2: A host read is waiting when hostReqValid=1, hostReqIsRead=1 and hostGrant=0. An I/O read is waiting when ioReqValid=1, ioReqIsRead=1 and ioGrant=0. If both are waiting in the same host-clock cycle, after synchronisation, while no split is held, hostSplit pulses high for exactly one host cycle, starting on the next host edge.
- R3: When only one side has a waiting read, no split is issued, however long that read waits.
- R4: A write on either bus (ReqIsRead=0) never causes a split.
- R5: A read whose interface already holds its grant is not waiting, so it never causes a split.
- R6: splitHeld rises on the same edge as hostSplit. It stays at 1 until the I/O side reports DMA read completion. No further split is issued while it is held, even if both reads wait again.
- R7: When the DMA completion is seen, hostRetry pulses high for exactly one host cycle, and splitHeld falls on the same edge.
- R8: splitCount rises by exactly one for each hostSplit pulse, saturates at its maximum value, and changes at no other time.
- R9: A single-I/O-cycle ioReadDone pulse produces exactly one hostRetry pulse, within a bounded number of host cycles.
- R10: Two reads that become valid together are treated like reads that overlap after arriving at different times, and they cause one split.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hostClk | input | 1 | Host bus clock |
| ioClk | input | 1 | I/O bus clock, asynchronous to hostClk |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| hostReqValid | input | 1 | Host-originated request toward the I/O bus is pending |
| hostReqIsRead | input | 1 | That host request is a read |
| hostGrant | input | 1 | Host request has won the I/O bus |
| ioReqValid | input | 1 | I/O-originated request toward host memory is pending (ioClk domain) |
| ioReqIsRead | input | 1 | That I/O request is a read (ioClk domain) |
| ioGrant | input | 1 | I/O request has won the host bus (ioClk domain) |
| ioReadDone | input | 1 | One-cycle pulse: DMA read return data delivered (ioClk domain) |
| hostSplit | output | 1 | One-cycle command to split the host transaction |
| hostRetry | output | 1 | One-cycle permission to reissue the split host read |
| splitHeld | output | 1 | A split is outstanding, waiting for DMA completion |
| splitCount | output | CNT_W | Saturating count of splits issued |

## Verification
On every host cycle, the assertions check the pulse shapes of the split and retry strobes. They also check that splitHeld rises with each split and falls with each retry, that no split occurs while one is held, that every split was preceded by a waiting host read, and that the counter steps only with splits. The bench scenarios are needed for the rest. They show that writes, granted reads and lone reads never split, that reads starting together or apart both lead to exactly one split, and that an I/O-clock completion pulse crosses the clock domains to give exactly one retry. Those behaviours depend on the I/O domain and the synchroniser, which single-domain properties cannot follow.

// File: rtl/bdb_pkg.sv
package bdb_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HELD = 1'b1
  } bdb_state_t;

  typedef struct packed {
    logic splitIssue;
    logic retryIssue;
  } bdb_strobe_t;

endpackage

// File: rtl/bdb_sync.sv
module bdb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/bdb_datapath.sv
module bdb_datapath
  import bdb_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit SATURATE    = 1'b1
) (
  input  logic              hostClk,
  input  logic              ioClk,
  input  logic              rstN,
  input  logic              hostReqValid,
  input  logic              hostReqIsRead,
  input  logic              hostGrant,
  input  logic              ioReqValid,
  input  logic              ioReqIsRead,
  input  logic              ioGrant,
  input  logic              ioReadDone,
  input  bdb_strobe_t       strobes,
  output logic              deadlockSeen,
  output logic              dmaDoneSeen,
  output logic              hostSplit,
  output logic              hostRetry,
  output logic [CNT_W-1:0]  splitCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  // I/O clock domain: register the status before it crosses
  logic ioWaitQ;
  logic doneTog;

  always_ff @(posedge ioClk or negedge rstN) begin
    if (!rstN) begin
      ioWaitQ <= 1'b0;
      doneTog <= 1'b0;
    end else begin
      ioWaitQ <= ioReqValid && ioReqIsRead && !ioGrant;
      if (ioReadDone) doneTog <= ~doneTog;
    end
  end

  // Crossing into the host domain
  logic ioWaitSync;
  logic doneTogSync;
  logic doneTogPrev;

  bdb_sync #(.STAGES(SYNC_STAGES)) i_waitSync (
    .clk(hostClk), .rstN(rstN), .d(ioWaitQ), .q(ioWaitSync)
  );

  bdb_sync #(.STAGES(SYNC_STAGES)) i_doneSync (
    .clk(hostClk), .rstN(rstN), .d(doneTog), .q(doneTogSync)
  );

  always_ff @(posedge hostClk or negedge rstN) begin
    if (!rstN) doneTogPrev <= 1'b0;
    else       doneTogPrev <= doneTogSync;
  end

  logic hostWait;
  assign hostWait     = hostReqValid && hostReqIsRead && !hostGrant;
  assign deadlockSeen = hostWait && ioWaitSync;
  assign dmaDoneSeen  = doneTogSync ^ doneTogPrev;

  // Registered host-side strobes
  always_ff @(posedge hostClk or negedge rstN) begin
    if (!rstN) begin
      hostSplit <= 1'b0;
      hostRetry <= 1'b0;
    end else begin
      hostSplit <= strobes.splitIssue;
      hostRetry <= strobes.retryIssue;
    end
  end

  // Split counter, saturating or wrapping by parameter
  generate
    if (SATURATE) begin : g_sat
      always_ff @(posedge hostClk or negedge rstN) begin
        if (!rstN)
          splitCount <= '0;
        else if (strobes.splitIssue && splitCount != CNT_MAX)
          splitCount <= splitCount + CNT_ONE;
      end
    end else begin : g_wrap
      always_ff @(posedge hostClk or negedge rstN) begin
        if (!rstN)
          splitCount <= '0;
        else if (strobes.splitIssue)
          splitCount <= splitCount + CNT_ONE;
      end
    end
  endgenerate
endmodule

// File: rtl/bdb_control.sv
module bdb_control
  import bdb_pkg::*;
(
  input  logic        hostClk,
  input  logic        rstN,
  input  logic        deadlockSeen,
  input  logic        dmaDoneSeen,
  output bdb_strobe_t strobes,
  output logic        splitHeld
);
  bdb_state_t state;
  bdb_state_t stateNext;

  always_comb begin
    stateNext          = state;
    strobes.splitIssue = 1'b0;
    strobes.retryIssue = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (deadlockSeen) begin
          strobes.splitIssue = 1'b1;
          stateNext          = ST_HELD;
        end
      end
      ST_HELD: begin
        if (dmaDoneSeen) begin
          strobes.retryIssue = 1'b1;
          stateNext          = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge hostClk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign splitHeld = (state == ST_HELD);
endmodule

// File: rtl/bdb_deadlock_breaker.sv
module bdb_deadlock_breaker
  import bdb_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit SATURATE    = 1'b1
) (
  input  logic             hostClk,
  input  logic             ioClk,
  input  logic             rstN,
  input  logic             hostReqValid,
  input  logic             hostReqIsRead,
  input  logic             hostGrant,
  input  logic             ioReqValid,
  input  logic             ioReqIsRead,
  input  logic             ioGrant,
  input  logic             ioReadDone,
  output logic             hostSplit,
  output logic             hostRetry,
  output logic             splitHeld,
  output logic [CNT_W-1:0] splitCount
);
  bdb_strobe_t strobes;
  logic        deadlockSeen;
  logic        dmaDoneSeen;

  bdb_datapath #(
    .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES), .SATURATE(SATURATE)
  ) i_datapath (
    .hostClk(hostClk), .ioClk(ioClk), .rstN(rstN),
    .hostReqValid(hostReqValid), .hostReqIsRead(hostReqIsRead), .hostGrant(hostGrant),
    .ioReqValid(ioReqValid), .ioReqIsRead(ioReqIsRead), .ioGrant(ioGrant),
    .ioReadDone(ioReadDone), .strobes(strobes),
    .deadlockSeen(deadlockSeen), .dmaDoneSeen(dmaDoneSeen),
    .hostSplit(hostSplit), .hostRetry(hostRetry), .splitCount(splitCount)
  );

  bdb_control i_control (
    .hostClk(hostClk), .rstN(rstN),
    .deadlockSeen(deadlockSeen), .dmaDoneSeen(dmaDoneSeen),
    .strobes(strobes), .splitHeld(splitHeld)
  );
endmodule

// File: rtl/bdb_checker.sv
module bdb_checker #(
  parameter int CNT_W = 8
) (
  input logic             hostClk,
  input logic             rstN,
  input logic             hostReqValid,
  input logic             hostReqIsRead,
  input logic             hostGrant,
  input logic             hostSplit,
  input logic             hostRetry,
  input logic             splitHeld,
  input logic [CNT_W-1:0] splitCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  a_r2_split_single_cycle: assert property (@(posedge hostClk) disable iff (!rstN)
    hostSplit |=> !hostSplit);

  a_r4_split_needs_host_read: assert property (@(posedge hostClk) disable iff (!rstN)
    hostSplit |-> $past(hostReqValid && hostReqIsRead && !hostGrant));

  a_r6_held_with_split: assert property (@(posedge hostClk) disable iff (!rstN)
    hostSplit |-> splitHeld);

  a_r6_no_split_while_held: assert property (@(posedge hostClk) disable iff (!rstN)
    hostSplit |-> !$past(splitHeld));

  a_r7_retry_single_cycle: assert property (@(posedge hostClk) disable iff (!rstN)
    hostRetry |=> !hostRetry);

  a_r7_retry_releases_hold: assert property (@(posedge hostClk) disable iff (!rstN)
    hostRetry |-> (!splitHeld && $past(splitHeld)));

  a_r7_no_split_with_retry: assert property (@(posedge hostClk) disable iff (!rstN)
    !(hostSplit && hostRetry));

  a_r8_count_steps: assert property (@(posedge hostClk) disable iff (!rstN)
    (hostSplit && $past(splitCount) != CNT_MAX) |-> splitCount == $past(splitCount) + CNT_ONE);

  a_r8_count_still: assert property (@(posedge hostClk) disable iff (!rstN)
    !hostSplit |-> $stable(splitCount));
endmodule

bind bdb_deadlock_breaker bdb_checker #(.CNT_W(CNT_W)) i_checker (
  .hostClk(hostClk), .rstN(rstN),
  .hostReqValid(hostReqValid), .hostReqIsRead(hostReqIsRead), .hostGrant(hostGrant),
  .hostSplit(hostSplit), .hostRetry(hostRetry), .splitHeld(splitHeld),
  .splitCount(splitCount)
);

// File: tb/test_bdb_deadlock_breaker.sv
module test_bdb_deadlock_breaker;
  localparam int CNT_W = 8;

  logic hostClk = 1'b0;
  logic ioClk = 1'b0;
  logic rstN = 1'b0;
  logic hostReqValid = 1'b0, hostReqIsRead = 1'b0, hostGrant = 1'b0;
  logic ioReqValid = 1'b0, ioReqIsRead = 1'b0, ioGrant = 1'b0, ioReadDone = 1'b0;
  logic hostSplit, hostRetry, splitHeld;
  logic [CNT_W-1:0] splitCount;

  always #10 hostClk = ~hostClk;  // 50 MHz
  always #7  ioClk = ~ioClk;      // unrelated I/O clock

  bdb_deadlock_breaker #(.CNT_W(CNT_W)) i_bdb_deadlock_breaker (
    .hostClk(hostClk), .ioClk(ioClk), .rstN(rstN),
    .hostReqValid(hostReqValid), .hostReqIsRead(hostReqIsRead), .hostGrant(hostGrant),
    .ioReqValid(ioReqValid), .ioReqIsRead(ioReqIsRead), .ioGrant(ioGrant),
    .ioReadDone(ioReadDone),
    .hostSplit(hostSplit), .hostRetry(hostRetry), .splitHeld(splitHeld),
    .splitCount(splitCount)
  );

  int checks = 0;
  int failures = 0;
  int splitSeen = 0;
  int retrySeen = 0;
  int expCount = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always @(negedge hostClk) begin
    if (rstN && hostSplit) splitSeen++;
    if (rstN && hostRetry) retrySeen++;
  end

  task automatic check(input int act, input int exp, input string req, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit expectSplit(input bit hV, input bit hR, input bit hG,
                                     input bit iV, input bit iR, input bit iG);
    return hV && hR && !hG && iV && iR && !iG;
  endfunction

  task automatic waitHost(input int n);
    for (int i = 0; i < n; i++) @(negedge hostClk);
  endtask

  task automatic setIo(input bit v, input bit r, input bit g);
    @(negedge ioClk);
    ioReqValid = v; ioReqIsRead = r; ioGrant = g;
  endtask

  task automatic setHost(input bit v, input bit r, input bit g);
    @(negedge hostClk);
    hostReqValid = v; hostReqIsRead = r; hostGrant = g;
  endtask

  task automatic runCase(input bit hV, input bit hR, input bit hG,
                         input bit iV, input bit iR, input bit iG,
                         input bit together, input string tag);
    int s0, r0;
    bit exp;
    exp = expectSplit(hV, hR, hG, iV, iR, iG);
    s0 = splitSeen; r0 = retrySeen;
    if (together) begin
      @(negedge hostClk);
      hostReqValid = hV; hostReqIsRead = hR; hostGrant = hG;
      ioReqValid = iV; ioReqIsRead = iR; ioGrant = iG;
    end else begin
      setIo(iV, iR, iG);
      waitHost(3);
      setHost(hV, hR, hG);
    end
    waitHost(15);
    if (exp && expCount < 255) expCount++;
    check(splitSeen - s0, int'(exp), tag, "split pulses (R2/R3/R4/R5)");
    check(int'(splitHeld), int'(exp), "R6", {tag, " held flag"});
    check(int'(splitCount), expCount, "R8", {tag, " split count"});
    setHost(1'b0, 1'b0, 1'b0);
    if (exp) begin
      waitHost(3);
      setHost(1'b1, 1'b1, 1'b0);   // host retries too early: both wait again
      waitHost(8);
      setHost(1'b0, 1'b0, 1'b0);
      check(splitSeen - s0, 1, "R6", {tag, " no split while held"});
      check(int'(splitHeld), 1, "R6", {tag, " held until completion"});
      check(retrySeen - r0, 0, "R7", {tag, " no early retry"});
      @(negedge ioClk);
      ioReadDone = 1'b1; ioReqValid = 1'b0;
      @(negedge ioClk);
      ioReadDone = 1'b0;
      waitHost(12);
      check(retrySeen - r0, 1, "R9", {tag, " one retry per completion"});
      check(int'(splitHeld), 0, "R7", {tag, " hold released"});
    end else begin
      setIo(1'b0, 1'b0, 1'b0);
      waitHost(8);
      check(retrySeen - r0, 0, "R7", {tag, " no retry without split"});
    end
  endtask

  initial begin
    void'($urandom(32'h0BDB_5EED));
    waitHost(3);
    check(int'(hostSplit), 0, "R1", "split in reset");
    check(int'(hostRetry), 0, "R1", "retry in reset");
    check(int'(splitHeld), 0, "R1", "held in reset");
    check(int'(splitCount), 0, "R1", "count in reset");
    @(negedge hostClk); rstN = 1'b1;
    @(negedge hostClk);
    check(int'(splitHeld) + int'(hostSplit) + int'(splitCount), 0, "R1", "state after reset");

    runCase(1,1,0, 0,0,0, 0, "R3 host read alone");
    runCase(0,0,0, 1,1,0, 0, "R3 io read alone");
    runCase(1,1,0, 1,0,0, 0, "R4 io write");
    runCase(1,0,0, 1,1,0, 0, "R4 host write");
    runCase(1,1,1, 1,1,0, 0, "R5 host granted");
    runCase(1,1,0, 1,1,1, 0, "R5 io granted");
    runCase(1,1,0, 1,1,0, 0, "R2 staggered reads");
    runCase(1,1,0, 1,1,0, 1, "R10 simultaneous reads");

    for (int it = 0; it < 40; it++) begin
      logic [5:0] b;
      b = 6'($urandom);
      runCase(b[0], b[1] | b[5], b[2] & b[4], b[3], b[4] | b[5], b[2] & ~b[4],
              bit'(it % 2), "R2 random");
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge hostClk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule